// File: doc/BRIEF.md
# Processor Idle State Signal Sequencer

This block sits on the chipset side of a processor and walks the CPU from its running state into one of four idle depths: C2, C3, C4 or a combined C5/C6. Software picks the depth by reading one of four level registers. The read arrives here as a one-cycle strobe carrying a two-bit depth code. The sequencer first trades handshake messages with the memory-controller side. It then raises a bank of seven power-control lines one at a time, from the shallowest to the deepest. The CPU stays in that state until a break event arrives.

A break event drops the lines again in reverse order, one step at a time. The block then sends GoC0 and waits for AckC0 before it accepts another request. Interrupts, SMI, NMI and a CPU error break wake the CPU from any depth. A bus-master snoop request wakes it only from C3 and C4. In C5/C6 the cache has already been flushed, so snoops need no service. A break that arrives partway through entry stops the entry and unwinds from wherever it had got to.

The delay between two successive line changes is set at run time through `step_dly`. Clock generation, regulator behaviour, cache flushing and C1 auto-halt belong to other blocks.

Top module: `cidle_seq`

## Requirements
- R1: During and after reset, `ctl_lines` is all zero and `msg_tx_valid` is low. While the block is idle, no line is asserted.
- R2: A `lvl_rd` strobe seen while idle latches `lvl_depth` (0=C2, 1=C3, 2=C4, 3=C5/C6) and produces a one-cycle message with code 0 (ReqC2) on the next cycle. A strobe seen while not idle has no effect.
- R3: When a message with code 1 (GoC2) arrives while the block waits for it, code 2 (AckC2) is sent on the next cycle. Line bit 0 rises one cycle after that. Each further line rises `step_dly`+1 cycles after the previous one.
- R4: Line bits are: 0 stop-clock request, 1 sleep, 2 deep sleep, 3 CPU clock stop, 4 deeper stop, 5 regulator low power, 6 sync. A resident state holds bits 0..1 for C2, 0..3 for C3, 0..5 for C4 and 0..6 for C5/C6. Lines only ever form a contiguous run starting at bit 0.
- R5: For C3 and C4, `step_dly`+1 cycles after bit 1 rises, code 3 (WaitC3) is sent. On receipt of code 4 (GoC3), code 5 (AckC3) follows on the next cycle, and the remaining lines then rise as in R3. C2 and C5/C6 never send WaitC3.
- R6: `brk_irq`, `brk_smi`, `brk_nmi` and `brk_ferr` are break events at every depth. `snoop_req` is a break event only when the requested depth is C3 or C4.
- R7: On a break, the highest asserted line drops on the next cycle. Each further line drops `step_dly`+1 cycles after the previous one. Code 6 (GoC0) is sent `step_dly`+1 cycles after the last line drops, never while any line is high.
- R8: A break during entry stops the entry at the current line count and unwinds as in R7. If no line is yet asserted, GoC0 is sent on the next cycle.
- R9: After GoC0, only code 7 (AckC0) returns the block to idle. Other received codes are ignored.
- R10: While waiting for a Go message, any received code other than the expected Go produces no response.
- R11: A break event while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_rd | input | 1 | Level register read strobe |
| lvl_depth | input | 2 | Depth requested by the read |
| step_dly | input | DLY_W | Extra cycles between line steps |
| brk_irq | input | 1 | Interrupt break event |
| brk_smi | input | 1 | SMI break event |
| brk_nmi | input | 1 | NMI break event |
| brk_ferr | input | 1 | CPU error break event |
| snoop_req | input | 1 | Bus-master snoop request |
| msg_rx_valid | input | 1 | Message from memory-controller side valid |
| msg_rx_code | input | 3 | Received message code |
| ctl_lines | output | 7 | Power-control lines, bit order per R4 |
| msg_tx_valid | output | 1 | Outgoing message valid, one cycle |
| msg_tx_code | output | 3 | Outgoing message code |

## Verification
The assertions assume that received messages and read strobes last exactly one cycle. They also assume that `step_dly` stays constant while a sequence is in flight, since the line spacing checks are counted against it. The stimulus holds `step_dly` steady for a whole entry and exit pass and pulses each message and strobe for one cycle only. Message codes that do not belong at a given point, such as a stray AckC0 during entry or a GoC2 during exit, are injected deliberately to exercise the ignore rules. Partner latency, depth, delay, abort point and break source are drawn at random from a fixed seed.

// File: rtl/cidle_pkg.sv
package cidle_pkg;

    localparam int NUM_LINES = 7;

    typedef enum logic [2:0] {
        MSG_REQ_C2  = 3'd0,
        MSG_GO_C2   = 3'd1,
        MSG_ACK_C2  = 3'd2,
        MSG_WAIT_C3 = 3'd3,
        MSG_GO_C3   = 3'd4,
        MSG_ACK_C3  = 3'd5,
        MSG_GO_C0   = 3'd6,
        MSG_ACK_C0  = 3'd7
    } msg_e;

    typedef enum logic [1:0] {
        DEP_C2  = 2'd0,
        DEP_C3  = 2'd1,
        DEP_C4  = 2'd2,
        DEP_C56 = 2'd3
    } depth_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_GO,
        ST_RAISE,
        ST_RESIDENT,
        ST_LOWER,
        ST_WAIT_ACK0
    } seq_st_e;

    // number of control lines held in the resident state of each depth
    function automatic int lines_for_depth(depth_e dep);
        case (dep)
            DEP_C2:  return 2;
            DEP_C3:  return 4;
            DEP_C4:  return 6;
            default: return NUM_LINES;
        endcase
    endfunction

    // depths that run the second (C3) message exchange
    function automatic logic needs_c3_xchg(depth_e dep);
        return (dep == DEP_C3) || (dep == DEP_C4);
    endfunction

endpackage

// File: rtl/cidle_brk_qual.sv
module cidle_brk_qual
    import cidle_pkg::*;
(
    input  logic   irq,
    input  logic   smi,
    input  logic   nmi,
    input  logic   ferr,
    input  logic   snoop,
    input  depth_e depth,
    output logic   brk
);
    logic snoop_breaks;

    // snoops only matter while caches are live but the CPU clock is stopped
    assign snoop_breaks = snoop && needs_c3_xchg(depth);
    assign brk          = irq || smi || nmi || ferr || snoop_breaks;

endmodule

// File: rtl/cidle_line_map.sv
module cidle_line_map #(
    parameter int NL = 7,
    parameter int CW = 3
) (
    input  logic [CW-1:0] cnt,
    output logic [NL-1:0] lines
);
    for (genvar i = 0; i < NL; i++) begin : g_line
        assign lines[i] = (cnt > CW'(i));
    end

endmodule

// File: rtl/cidle_seq.sv
module cidle_seq
    import cidle_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_rd,
    input  logic [1:0]       lvl_depth,
    input  logic [DLY_W-1:0] step_dly,
    input  logic             brk_irq,
    input  logic             brk_smi,
    input  logic             brk_nmi,
    input  logic             brk_ferr,
    input  logic             snoop_req,
    input  logic             msg_rx_valid,
    input  logic [2:0]       msg_rx_code,
    output logic [6:0]       ctl_lines,
    output logic             msg_tx_valid,
    output logic [2:0]       msg_tx_code
);
    localparam int CNT_W    = $clog2(NUM_LINES + 1);
    localparam int C2_LINES = 2;

    typedef struct packed {
        seq_st_e          st;
        depth_e           depth;
        logic             c3_phase;
        logic [CNT_W-1:0] cnt;
        logic [DLY_W-1:0] tmr;
        logic             tx_v;
        msg_e             tx_c;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:       ST_IDLE,
        depth:    DEP_C2,
        c3_phase: 1'b0,
        cnt:      '0,
        tmr:      '0,
        tx_v:     1'b0,
        tx_c:     MSG_REQ_C2
    };

    seq_t q, d;
    logic brk;
    logic [CNT_W-1:0] tgt;
    msg_e rx_c;
    msg_e go_exp;
    logic [NUM_LINES-1:0] lines_w;

    assign rx_c   = msg_e'(msg_rx_code);
    assign go_exp = q.c3_phase ? MSG_GO_C3 : MSG_GO_C2;

    cidle_brk_qual u_brk (
        .irq   (brk_irq),
        .smi   (brk_smi),
        .nmi   (brk_nmi),
        .ferr  (brk_ferr),
        .snoop (snoop_req),
        .depth (q.depth),
        .brk   (brk)
    );

    cidle_line_map #(.NL(NUM_LINES), .CW(CNT_W)) u_map (
        .cnt   (q.cnt),
        .lines (lines_w)
    );

    // line count to reach in the current entry phase
    always_comb begin
        if (!q.c3_phase && needs_c3_xchg(q.depth)) tgt = CNT_W'(C2_LINES);
        else                                        tgt = CNT_W'(lines_for_depth(q.depth));
    end

    always_comb begin
        logic unwind;
        d      = q;
        d.tx_v = 1'b0;
        unwind = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (lvl_rd) begin
                    d.depth    = depth_e'(lvl_depth);
                    d.c3_phase = 1'b0;
                    d.tx_v     = 1'b1;
                    d.tx_c     = MSG_REQ_C2;
                    d.st       = ST_WAIT_GO;
                end
            end
            ST_WAIT_GO: begin
                if (brk) begin
                    unwind = 1'b1;
                end else if (msg_rx_valid && rx_c == go_exp) begin
                    d.tx_v = 1'b1;
                    d.tx_c = q.c3_phase ? MSG_ACK_C3 : MSG_ACK_C2;
                    d.tmr  = '0;
                    d.st   = ST_RAISE;
                end
            end
            ST_RAISE: begin
                if (brk) begin
                    unwind = 1'b1;
                end else if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else if (q.cnt < tgt) begin
                    d.cnt = q.cnt + 1'b1;
                    d.tmr = step_dly;
                end else if (!q.c3_phase && needs_c3_xchg(q.depth)) begin
                    d.tx_v     = 1'b1;
                    d.tx_c     = MSG_WAIT_C3;
                    d.c3_phase = 1'b1;
                    d.st       = ST_WAIT_GO;
                end else begin
                    d.st = ST_RESIDENT;
                end
            end
            ST_RESIDENT: begin
                if (brk) unwind = 1'b1;
            end
            ST_LOWER: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                    d.tmr = step_dly;
                end else begin
                    d.tx_v = 1'b1;
                    d.tx_c = MSG_GO_C0;
                    d.st   = ST_WAIT_ACK0;
                end
            end
            ST_WAIT_ACK0: begin
                if (msg_rx_valid && rx_c == MSG_ACK_C0) d.st = ST_IDLE;
            end
            default: d = SEQ_RST;
        endcase

        // break handling common to entry and resident states
        if (unwind) begin
            if (q.cnt != '0) begin
                d.cnt = q.cnt - 1'b1;
                d.tmr = step_dly;
                d.st  = ST_LOWER;
            end else begin
                d.tx_v = 1'b1;
                d.tx_c = MSG_GO_C0;
                d.st   = ST_WAIT_ACK0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign ctl_lines    = lines_w;
    assign msg_tx_valid = q.tx_v;
    assign msg_tx_code  = q.tx_c;

    // R1: nothing driven while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (ctl_lines == '0));

    // R3: first line follows the AckC2 message by one cycle
    a_r3_ack_before_lines: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_lines[0]) |-> ($past(msg_tx_valid) && $past(msg_tx_code) == MSG_ACK_C2));

    // R3, R7: lines change one at a time
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(ctl_lines ^ $past(ctl_lines)) <= 1));

    // R4: never more lines than the requested depth allows
    a_r4_depth_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ctl_lines) <= lines_for_depth(q.depth)));

    // R5: the C3 exchange only for C3 and C4
    a_r5_wait_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_tx_valid && msg_tx_code == MSG_WAIT_C3) |-> needs_c3_xchg(q.depth));

    // R7: GoC0 only once every line is down
    a_r7_exit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_tx_valid && msg_tx_code == MSG_GO_C0) |-> (ctl_lines == '0));

endmodule

// File: tb/sim_cidle_seq.sv
module sim_cidle_seq;
    import cidle_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lvl_rd = 1'b0;
    logic [1:0] lvl_depth = 2'd0;
    logic [7:0] step_dly = 8'd0;
    logic       brk_irq = 1'b0, brk_smi = 1'b0, brk_nmi = 1'b0, brk_ferr = 1'b0;
    logic       snoop_req = 1'b0;
    logic       msg_rx_valid = 1'b0;
    logic [2:0] msg_rx_code = 3'd0;
    logic [6:0] ctl_lines;
    logic       msg_tx_valid;
    logic [2:0] msg_tx_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cidle_seq #(.DLY_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .lvl_rd(lvl_rd), .lvl_depth(lvl_depth),
        .step_dly(step_dly), .brk_irq(brk_irq), .brk_smi(brk_smi),
        .brk_nmi(brk_nmi), .brk_ferr(brk_ferr), .snoop_req(snoop_req),
        .msg_rx_valid(msg_rx_valid), .msg_rx_code(msg_rx_code),
        .ctl_lines(ctl_lines), .msg_tx_valid(msg_tx_valid), .msg_tx_code(msg_tx_code)
    );

    function automatic int therm(int k);
        return (1 << k) - 1;
    endfunction

    function automatic int target(int dep);
        case (dep)
            0: return 2;
            1: return 4;
            2: return 6;
            default: return 7;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_msg(input string tag, input int code);
        chk({tag, " msg valid"}, int'(msg_tx_valid), 1);
        chk({tag, " msg code"}, int'(msg_tx_code), code);
    endtask

    task automatic quiet(input int n, input int lines_exp, input string tag);
        for (int i = 0; i < n; i++) begin
            step();
            chk({tag, " lines"}, int'(ctl_lines), lines_exp);
            chk({tag, " no msg"}, int'(msg_tx_valid), 0);
        end
    endtask

    task automatic send_rx(input int code);
        msg_rx_valid = 1'b1;
        msg_rx_code  = 3'(code);
        step();
        msg_rx_valid = 1'b0;
    endtask

    task automatic set_brk(input int src, input bit v);
        case (src)
            0: brk_irq   = v;
            1: brk_smi   = v;
            2: brk_nmi   = v;
            3: brk_ferr  = v;
            default: snoop_req = v;
        endcase
    endtask

    // entry; stop_at = 0 aborts before the first Go, k stops after line k
    task automatic enter(input int dep, input int dly, input int stop_at);
        int tgt = target(dep);
        bit c3 = (dep == 1) || (dep == 2);
        int first_n = c3 ? 2 : tgt;
        step_dly  = 8'(dly);
        lvl_rd    = 1'b1;
        lvl_depth = 2'(dep);
        step();
        lvl_rd = 1'b0;
        chk_msg("R2 req", int'(MSG_REQ_C2));
        chk("R2 lines at req", int'(ctl_lines), 0);
        if (stop_at == 0) return;
        quiet(int'($urandom % 3), 0, "R10 await go");
        send_rx(int'(MSG_ACK_C0));
        chk("R10 stray code ignored", int'(msg_tx_valid), 0);
        send_rx(int'(MSG_GO_C2));
        chk_msg("R3 ack c2", int'(MSG_ACK_C2));
        for (int k = 1; k <= first_n; k++) begin
            if (k > 1) quiet(dly, therm(k - 1), "R3 gap");
            step();
            chk("R3 R4 raise", int'(ctl_lines), therm(k));
            chk("R3 no msg at raise", int'(msg_tx_valid), 0);
            if (k == stop_at) return;
        end
        if (c3) begin
            quiet(dly, therm(2), "R5 before wait");
            step();
            chk_msg("R5 wait c3", int'(MSG_WAIT_C3));
            quiet(int'($urandom % 3), therm(2), "R5 await go c3");
            send_rx(int'(MSG_GO_C2));
            chk("R10 wrong go ignored", int'(msg_tx_valid), 0);
            send_rx(int'(MSG_GO_C3));
            chk_msg("R5 ack c3", int'(MSG_ACK_C3));
            for (int k = 3; k <= tgt; k++) begin
                if (k > 3) quiet(dly, therm(k - 1), "R5 gap");
                step();
                chk("R4 R5 raise", int'(ctl_lines), therm(k));
                if (k == stop_at) return;
            end
        end
        quiet(dly + 3, therm(tgt), "R4 R5 resident");
    endtask

    task automatic leave(input int nl, input int dly, input int src);
        set_brk(src, 1'b1);
        step();
        set_brk(src, 1'b0);
        if (nl == 0) begin
            chk_msg("R8 abort before lines", int'(MSG_GO_C0));
        end else begin
            chk("R7 R8 first drop", int'(ctl_lines), therm(nl - 1));
            chk("R7 no msg at drop", int'(msg_tx_valid), 0);
            for (int cur = nl - 1; cur > 0; cur--) begin
                quiet(dly, therm(cur), "R7 gap");
                step();
                chk("R7 drop", int'(ctl_lines), therm(cur - 1));
            end
            quiet(dly, 0, "R7 before go c0");
            step();
            chk_msg("R7 go c0", int'(MSG_GO_C0));
        end
        quiet(int'($urandom % 3), 0, "R9 await ack c0");
        send_rx(int'(MSG_GO_C2));
        chk("R9 stray code ignored", int'(msg_tx_valid), 0);
        lvl_rd = 1'b1;
        send_rx(int'(MSG_GO_C3));
        lvl_rd = 1'b0;
        chk("R2 R9 read while busy ignored", int'(msg_tx_valid), 0);
        send_rx(int'(MSG_ACK_C0));
        chk("R9 ack c0 lines", int'(ctl_lines), 0);
        quiet(2, 0, "R9 back to idle");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        // R1 reset state
        repeat (3) step();
        chk("R1 reset lines", int'(ctl_lines), 0);
        chk("R1 reset msg", int'(msg_tx_valid), 0);
        rst_n = 1'b1;
        quiet(2, 0, "R1 after reset");

        // R11 break while idle
        brk_irq = 1'b1; snoop_req = 1'b1;
        quiet(3, 0, "R11 break idle");
        brk_irq = 1'b0; snoop_req = 1'b0;

        // directed: each depth fully, exit by each source
        enter(0, 0, 99); leave(2, 0, 0);
        enter(1, 1, 99); leave(4, 1, 4);
        enter(2, 2, 99); leave(6, 2, 1);
        enter(3, 0, 99); leave(7, 0, 2);

        // R6 snoop ignored at C2 and C5/C6
        enter(0, 1, 99);
        snoop_req = 1'b1;
        quiet(4, therm(2), "R6 snoop c2");
        snoop_req = 1'b0;
        leave(2, 1, 3);
        enter(3, 1, 99);
        snoop_req = 1'b1;
        quiet(4, therm(7), "R6 snoop c56");
        snoop_req = 1'b0;
        leave(7, 1, 0);

        // R2 read while resident ignored
        enter(0, 0, 99);
        lvl_rd = 1'b1; lvl_depth = 2'd2;
        step();
        lvl_rd = 1'b0;
        chk("R2 busy read no msg", int'(msg_tx_valid), 0);
        chk("R2 busy read lines", int'(ctl_lines), therm(2));
        leave(2, 0, 1);

        // R8 aborts
        enter(2, 0, 0); leave(0, 0, 0);
        enter(2, 2, 3); leave(3, 2, 4);
        enter(1, 1, 2); leave(2, 1, 2);
        enter(3, 3, 5); leave(5, 3, 3);

        // random mix
        for (int it = 0; it < 30; it++) begin
            int dep = int'($urandom % 4);
            int dly = int'($urandom % 4);
            int tgt = target(dep);
            int stop = int'($urandom % (tgt + 1));
            int nl;
            int src = ((dep == 1) || (dep == 2)) ? int'($urandom % 5) : int'($urandom % 4);
            if (stop == tgt) stop = 99;
            nl = (stop == 99) ? tgt : stop;
            enter(dep, dly, stop);
            leave(nl, dly, src);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule